// File: doc/BRIEF.md
# Fixed-Point Vector Multiply Unit

This block executes the multiply-group instructions of a small vector coprocessor. It holds a 128-entry file of 32-bit registers. It accepts one decoded 32-bit instruction word at a time. It then walks a run of consecutive registers, one element per clock cycle.

Each element multiplies operand A by a 16-bit operand. A is either the sign-extended low half of its register (16x16 forms) or the whole register (32x16 forms). The 16-bit operand is the low half of B, or of the scalar register in the scaled-add mode. The result can be shifted right by 8 or 16 bits, optionally with rounding, before it is written to the destination. A dot-product mode sums all element products and writes a single result.

A side port lets the surrounding logic preload and inspect the register file. Register 0 always reads as zero. Register 1 is the scalar operand of the scaled-add mode.

Top module: `vmul_unit`

## Requirements
- R1: After reset, `busy` and `done` are low and every register reads zero. A reset applied in the middle of a run ends the run and clears the registers.
- R2: Register 0 reads as zero at all times. Writes to it, from the side port or from the engine, are dropped.
- R3: The instruction fields are: form at bits 31:28, count at 27:24, round at 23, operation at 22:21, A register at 20:14, destination at 13:7, B register at 6:0. In forms 0, 1 and 2, each element multiplies signed A[15:0] by a signed 16-bit operand. The product is then shifted arithmetically right by 0, 8 or 16 bits, and its low 32 bits are kept.
- R4: Forms 4, 5 and 6 behave like forms 0, 1 and 2, except that A is the full signed 32-bit register.
- R5: With the round bit set and a shift of s (8 or 16), 2^(s-1) is added before the shift. With no shift, the round bit has no effect.
- R6: Operation 2 (scaled add) multiplies A by the signed low half of register 1. It then adds the full 32-bit B register to the shifted product. Register 1 is read afresh for each element.
- R7: Operation 1 (dot product) sums the products of all elements in a 56-bit signed sum. It applies the shift and rounding to that sum and writes it once, to the destination register only.
- R8: Operation 0 writes each shifted product to its destination. An instruction handles count+1 elements, one per cycle, with `busy` high for exactly count+1 cycles. The A, B and destination indices rise by one per element and wrap modulo 128. Each element sees the writes of the elements before it.
- R9: `done` is a one-cycle pulse in the cycle after the last write-back, with `busy` already low. A new instruction presented in that cycle is accepted.
- R10: A word with bit 31 set, a shift code (bits 29:28) of 3, or an operation code of 3 is ignored. It raises neither `busy` nor `done` and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word present; taken when `busy` is low |
| instr_word | input | 32 | Decoded multiply-group instruction |
| busy | output | 1 | Unit is processing elements |
| done | output | 1 | One-cycle pulse after the final write-back |
| host_we | input | 1 | Side-port register write enable |
| host_addr | input | 7 | Side-port write address |
| host_wdata | input | 32 | Side-port write data |
| rd_addr | input | 7 | Side-port read address |
| rd_data | output | 32 | Register contents at `rd_addr` (combinational) |

## Verification
Two events can fall in the same cycle: the completion pulse of one instruction and the acceptance of the next. The bench provokes this by holding `instr_valid` with a second word through the whole first run. It expects `done` in the cycle after the last element, and `busy` high again in the cycle after that. Both results are then compared against a bench model of the register file. Within a run, the write-back of one element and the operand read of the next also meet on the same register. Overlapping A and destination ranges, and a scaled add that overwrites register 1, check that each element sees its predecessor's result.

// File: rtl/vmul_unit.sv
module vmul_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  input  logic [31:0] instr_word,
  output logic        busy,
  output logic        done,
  input  logic        host_we,
  input  logic [6:0]  host_addr,
  input  logic [31:0] host_wdata,
  input  logic [6:0]  rd_addr,
  output logic [31:0] rd_data
);
  localparam int AW   = 7;
  localparam int DW   = 32;
  localparam int NREG = 1 << AW;
  localparam int PW   = DW + 16;
  localparam int ACCW = PW + 8;
  localparam logic [1:0] OP_MUL = 2'd0, OP_DOT = 2'd1, OP_SAXP = 2'd2;

  logic [DW-1:0] regs [NREG];
  logic          busy_q, done_q, wide_q, rnd_q;
  logic [1:0]    sh_q, op_q;
  logic [3:0]    left_q;
  logic [AW-1:0] a_idx, b_idx, d_idx;
  logic signed [ACCW-1:0] acc_q;

  wire [1:0] f_sh   = instr_word[29:28];
  wire [1:0] f_op   = instr_word[22:21];
  wire       legal  = !instr_word[31] && (f_sh != 2'd3) && (f_op != 2'd3);
  wire       accept = instr_valid && !busy_q && legal;
  wire       last   = (left_q == 4'd0);

  wire [DW-1:0] a_v = (a_idx == '0) ? '0 : regs[a_idx];
  wire [DW-1:0] b_v = (b_idx == '0) ? '0 : regs[b_idx];
  wire [DW-1:0] s_v = regs[1];
  wire [DW-1:0] m_v = (op_q == OP_SAXP) ? s_v : b_v;

  logic signed [DW-1:0]   a_op;
  logic signed [15:0]     m_op;
  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prod_w, acc_sum;
  logic [DW-1:0]          shifted, wr_val;

  function automatic logic [DW-1:0] rshift(input logic signed [ACCW-1:0] x,
                                           input logic [1:0] code, input logic r);
    logic signed [ACCW-1:0] t;
    t = x;
    if (r && code == 2'd1) t = t + ACCW'(128);
    if (r && code == 2'd2) t = t + ACCW'(32768);
    if (code == 2'd1)      t = t >>> 8;
    else if (code == 2'd2) t = t >>> 16;
    return t[DW-1:0];
  endfunction

  always_comb begin
    a_op    = wide_q ? $signed(a_v) : DW'($signed(a_v[15:0]));
    m_op    = $signed(m_v[15:0]);
    prod    = PW'(a_op) * PW'(m_op);
    prod_w  = ACCW'(prod);
    acc_sum = acc_q + prod_w;
    shifted = rshift((op_q == OP_DOT) ? acc_sum : prod_w, sh_q, rnd_q);
    wr_val  = (op_q == OP_SAXP) ? shifted + b_v : shifted;
  end

  wire eng_we = busy_q && ((op_q != OP_DOT) || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (eng_we) begin
      if (d_idx != '0) regs[d_idx] <= wr_val;
    end else if (host_we && host_addr != '0) begin
      regs[host_addr] <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wide_q <= 1'b0;
      rnd_q  <= 1'b0;
      sh_q   <= '0;
      op_q   <= '0;
      left_q <= '0;
      a_idx  <= '0;
      b_idx  <= '0;
      d_idx  <= '0;
      acc_q  <= '0;
    end else begin
      done_q <= busy_q && last;
      if (accept) begin
        busy_q <= 1'b1;
        wide_q <= instr_word[30];
        sh_q   <= f_sh;
        op_q   <= f_op;
        rnd_q  <= instr_word[23];
        left_q <= instr_word[27:24];
        a_idx  <= instr_word[20:14];
        d_idx  <= instr_word[13:7];
        b_idx  <= instr_word[6:0];
        acc_q  <= '0;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
        end else begin
          left_q <= left_q - 4'd1;
          a_idx  <= a_idx + 7'd1;
          b_idx  <= b_idx + 7'd1;
          if (op_q != OP_DOT) d_idx <= d_idx + 7'd1;
          acc_q  <= acc_sum;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = (rd_addr == '0) ? '0 : regs[rd_addr];
endmodule

// File: rtl/vmul_unit_chk.sv
module vmul_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic [31:0] instr_word,
  input logic        busy,
  input logic        done,
  input logic [6:0]  rd_addr,
  input logic [31:0] rd_data
);
  logic [31:0] held_word;
  logic [4:0]  run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_word <= '0;
      run_cnt   <= '0;
    end else begin
      if (!busy) held_word <= instr_word;
      run_cnt <= busy ? run_cnt + 5'd1 : 5'd0;
    end
  end

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r9_start_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(instr_valid));

  a_r8_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == {1'b0, held_word[27:24]} + 5'd1));

  a_r10_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !busy && (instr_word[31] || instr_word[29:28] == 2'd3 ||
     instr_word[22:21] == 2'd3)) |=> !busy);

  a_r2_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 7'd0) |-> (rd_data == 32'd0));
endmodule

bind vmul_unit vmul_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
  .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/vmul_unit_tb.sv
module vmul_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        busy, done;
  logic        host_we = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [6:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [31:0] m [128];

  always #2 clk = ~clk;

  vmul_unit u_dut (.*);

  function automatic logic [31:0] mk(input int form, input int cnt, input int rnd,
                                     input int op, input int sa, input int d, input int sb);
    return {form[3:0], cnt[3:0], rnd[0], op[1:0], sa[6:0], d[6:0], sb[6:0]};
  endfunction

  localparam int NV = 13;
  localparam logic [31:0] VEC [NV] = '{
    mk(0, 3, 0, 0, 10, 40, 20),
    mk(1, 2, 0, 0, 12, 50, 22),
    mk(2, 1, 1, 0, 14, 60, 24),
    mk(4, 3, 0, 0, 16, 70, 26),
    mk(5, 0, 1, 0, 18, 71, 28),
    mk(6, 15, 0, 0, 100, 120, 110),
    mk(0, 4, 0, 2, 30, 80, 35),
    mk(1, 2, 1, 2, 33, 85, 44),
    mk(0, 7, 0, 1, 40, 90, 50),
    mk(6, 15, 1, 1, 5, 91, 60),
    mk(0, 2, 1, 0, 9, 95, 11),
    mk(0, 5, 0, 0, 30, 31, 2),
    mk(0, 3, 0, 2, 20, 1, 21)
  };

  function automatic longint rs(input longint x, input int code, input bit r);
    longint t = x;
    if (r && code == 1) t += 128;
    if (r && code == 2) t += 32768;
    if (code == 1) t = t >>> 8;
    else if (code == 2) t = t >>> 16;
    return t;
  endfunction

  task automatic model_exec(input logic [31:0] w);
    int code = int'(w[29:28]);
    int cnt  = int'(w[27:24]);
    int op   = int'(w[22:21]);
    longint acc = 0;
    for (int i = 0; i <= cnt; i++) begin
      logic [31:0] av, bv, mv;
      longint a, b, p, r;
      int di;
      av = m[(int'(w[20:14]) + i) % 128];
      bv = m[(int'(w[6:0]) + i) % 128];
      mv = (op == 2) ? m[1] : bv;
      a  = w[30] ? longint'($signed(av)) : longint'($signed(av[15:0]));
      b  = longint'($signed(mv[15:0]));
      p  = a * b;
      if (op == 1) acc += p;
      else begin
        r = rs(p, code, w[23]);
        if (op == 2) r += longint'($signed(bv));
        di = (int'(w[13:7]) + i) % 128;
        if (di != 0) m[di] = r[31:0];
      end
    end
    if (op == 1 && w[13:7] != 0) begin
      longint r2 = rs(acc, code, w[23]);
      m[w[13:7]] = r2[31:0];
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input int a, input logic [31:0] v);
    host_we = 1'b1; host_addr = a[6:0]; host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
    if (a != 0) m[a] = v;
  endtask

  task automatic hread(input int a, output logic [31:0] v);
    rd_addr = a[6:0];
    #0.5;
    v = rd_data;
  endtask

  task automatic compare_all(input string req);
    int bad = -1;
    logic [31:0] v, ev;
    ev = '0;
    v = '0;
    for (int i = 0; i < 128; i++) begin
      logic [31:0] t;
      hread(i, t);
      if (bad < 0 && t !== m[i]) begin bad = i; v = t; ev = m[i]; end
    end
    if (bad >= 0) $display("FAIL detail %s: register %0d", req, bad);
    check(bad < 0, req, v, ev);
    @(negedge clk);
  endtask

  task automatic issue(input logic [31:0] w, input string req);
    int lat = 1;
    instr_valid = 1'b1; instr_word = w;
    @(negedge clk);
    instr_valid = 1'b0;
    check(busy === 1'b1, {req, " busy after accept (R8)"}, 32'(busy), 1);
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    check(lat == int'(w[27:24]) + 2, {req, " done latency (R9)"}, lat, int'(w[27:24]) + 2);
    @(negedge clk);
    check(done === 1'b0, {req, " done is one pulse (R9)"}, 32'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 128; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 reset outputs", {30'd0, busy, done}, 0);
    compare_all("R1 registers zero after reset");

    hwrite(0, 32'hFFFF_FFFF);
    hread(0, v);
    check(v === 32'd0, "R2 host write to register 0 dropped", v, 0);
    @(negedge clk);

    for (int i = 1; i < 128; i++) hwrite(i, (32'(i) * 32'h9E37_79B9) ^ (32'(i) << 19));

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("vector %0d (R3 R4 R5 R6 R7 R8)", k);
      model_exec(VEC[k]);
      issue(VEC[k], tag);
      compare_all(tag);
    end

    hwrite(2, 32'h0000_00FF); hwrite(3, 32'h0000_0001);
    issue(mk(1, 0, 1, 0, 2, 4, 3), "R5 directed");
    hread(4, v); check(v === 32'd1, "R5 round 255>>8 up", v, 1);
    @(negedge clk);
    issue(mk(1, 0, 0, 0, 2, 4, 3), "R3 directed");
    hread(4, v); check(v === 32'd0, "R3 truncate 255>>8", v, 0);
    @(negedge clk);
    hwrite(2, 32'h1234_FFFF);
    issue(mk(1, 0, 0, 0, 2, 4, 3), "R3 directed neg");
    hread(4, v); check(v === 32'hFFFF_FFFF, "R3 arithmetic shift of -1", v, 32'hFFFF_FFFF);
    @(negedge clk);
    hwrite(2, 32'h0001_0000); hwrite(3, 32'h0000_0002);
    issue(mk(4, 0, 0, 0, 2, 4, 3), "R4 directed");
    hread(4, v); check(v === 32'h0002_0000, "R4 full-width A", v, 32'h0002_0000);
    @(negedge clk);
    issue(mk(0, 0, 0, 0, 2, 4, 3), "R3 directed low half");
    hread(4, v); check(v === 32'd0, "R3 low half of A only", v, 0);
    @(negedge clk);
    hwrite(2, 2); hwrite(3, 4); hwrite(5, 3); hwrite(6, 5); hwrite(7, 32'hDEAD_BEEF);
    issue(mk(0, 1, 0, 1, 2, 7, 5), "R7 directed");
    hread(7, v); check(v === 32'd26, "R7 dot 2*3+4*5", v, 26);
    hread(8, v); check(v === m[8], "R7 single write only", v, m[8]);
    @(negedge clk);
    for (int i = 1; i < 128; i++) m[i] = m[i];
    m[4] = 32'd0; m[7] = 32'd26;

    begin
      logic [31:0] w1, w2;
      w1 = mk(0, 2, 0, 0, 10, 60, 20);
      w2 = mk(1, 1, 1, 2, 60, 64, 21);
      model_exec(w1);
      model_exec(w2);
      instr_valid = 1'b1; instr_word = w1;
      @(negedge clk);
      instr_word = w2;
      while (!done) @(negedge clk);
      check(busy === 1'b0, "R9 busy low in done cycle", 32'(busy), 0);
      @(negedge clk);
      instr_valid = 1'b0;
      check(busy === 1'b1 && done === 1'b0, "R9 next accepted in done cycle",
            {30'd0, busy, done}, 32'd2);
      while (!done) @(negedge clk);
      @(negedge clk);
      compare_all("R9 back-to-back results");
    end

    instr_valid = 1'b1; instr_word = mk(3, 2, 0, 0, 10, 40, 20);
    @(negedge clk);
    instr_word = mk(0, 2, 0, 3, 10, 40, 20);
    @(negedge clk);
    instr_word = 32'h8000_0000 | mk(0, 2, 0, 0, 10, 40, 20);
    @(negedge clk);
    instr_valid = 1'b0;
    check(busy === 1'b0 && done === 1'b0, "R10 illegal words ignored", {30'd0, busy, done}, 0);
    repeat (3) @(negedge clk);
    check(done === 1'b0, "R10 no done", 32'(done), 0);
    compare_all("R10 registers unchanged");

    instr_valid = 1'b1; instr_word = mk(0, 15, 0, 0, 10, 40, 20);
    @(negedge clk);
    instr_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 128; i++) m[i] = '0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 reset mid-run", {30'd0, busy, done}, 0);
    compare_all("R1 registers cleared mid-run");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule